// File: doc/BRIEF.md
# Phase-Zero SPI Slave

This block is a byte-wide serial slave for the clock-phase-zero SPI format, with the idle level of the serial clock chosen by an input. A transfer opens when the select line falls. Exactly eight serial clock cycles follow, and the line must go high again before the next byte. The slave captures the incoming data line most significant bit first, on the leading clock edge of each cycle. It moves its own transmit byte out on the trailing edges.

The serial pins come from outside the chip. They pass through synchronizers clocked by the system clock, which must run at least four times faster than the serial clock. Edges are found in the system clock domain.

On the local side, the host loads the next transmit byte through a load strobe. A ready flag shows whether a loaded byte is still waiting to be sent. Each completed byte appears on a parallel output with a one-cycle valid strobe. Two error pulses report when a select cycle ends early and when a byte is sent again because none was loaded.

Top module: `spi_slave_cpha0`

## Requirements
- R1: After reset, `rx_valid_o`, `abort_o` and `underrun_o` are low, `rx_data_o` is 8'h00 and `tx_ready_o` is high.
- R2: `miso_oe_o` is high exactly while `ss_n_i` is low; while `ss_n_i` is high the output is released (`miso_oe_o` low).
- R3: When the select falls, `miso_o` already carries bit 7 of the byte that was loaded at least three system clocks earlier, before any serial clock edge.
- R4: Incoming data is sampled on the leading edge of each serial clock cycle and assembled MSB first. With `cpol_i`=0 the leading edge is rising; with `cpol_i`=1 it is falling.
- R5: After each trailing edge, `miso_o` moves to the next lower bit, so the master reads bits 7 down to 0 of the transmit byte on its eight leading edges.
- R6: After the eighth leading edge, `rx_data_o` takes the received byte and `rx_valid_o` is high for exactly one system clock.
- R7: Once eight bits have been taken, further serial clock cycles under the same select have no effect: no extra `rx_valid_o` pulse, and `rx_data_o` is unchanged.
- R8: If the select rises before eight bits have been taken, the partial byte is dropped and `abort_o` pulses for one clock without any `rx_valid_o` pulse. The next transfer starts again at bit 7.
- R9: If the select falls while no new byte has been loaded since the previous transfer began, the previous transmit byte is sent again and `underrun_o` pulses for one clock.
- R10: `tx_ready_o` goes low on the clock after a load strobe. It returns high once a transfer begins and takes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpol_i | input | 1 | Serial clock idle level (0 = idles low, 1 = idles high) |
| tx_load_i | input | 1 | Strobe that stores `tx_data_i` as the next byte to send |
| tx_data_i | input | 8 | Next transmit byte |
| tx_ready_o | output | 1 | High when no loaded byte is waiting |
| rx_data_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_data_o` is updated |
| abort_o | output | 1 | One-cycle pulse when a transfer is cut short |
| underrun_o | output | 1 | One-cycle pulse when a byte is sent again without a new load |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to the master (low while released) |
| miso_oe_o | output | 1 | Output enable for the serial data pin |

## Verification
The main exchange runs with byte pairs chosen to catch specific faults. Alternating and complementary patterns catch a reversed or off-by-one shift. All-zero and all-one bytes catch a stuck line. Single set bits at either end catch a lost first or last bit. These pairs run under both clock polarities, so a design that samples on the wrong edge receives a shifted byte. Directed runs then cut a transfer short, send without a new load, and keep clocking after the eighth bit. Together these separate a counter that is not cleared, a transmit byte that is not held, and a byte that is taken twice.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // Transfer progress inside one select cycle
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } xfer_state_e;

  // Positions of the serial pins inside the synchronizer vector
  localparam int PIN_MOSI = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SS   = 2;
  localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_slv_txbuf.sv
module spi_slv_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  output logic [DATA_W-1:0] word_o,
  output logic              ready_o,
  output logic              underrun_o
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              fresh_q, fresh_d;
  logic              urun_q, urun_d;

  always_comb begin
    hold_d  = hold_q;
    fresh_d = fresh_q;
    if (start_i) fresh_d = 1'b0;
    if (load_i) begin
      hold_d  = data_i;
      fresh_d = 1'b1;
    end
    urun_d = start_i & ~fresh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      fresh_q <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      fresh_q <= fresh_d;
      urun_q  <= urun_d;
    end
  end

  assign word_o     = hold_q;
  assign ready_o    = ~fresh_q;
  assign underrun_o = urun_q;

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ready_o);

  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i) |=> ready_o);

  // R9
  underrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> $past(ready_o));

endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              ss_n_s_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              start_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              abort_o,
  output logic              miso_o
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int LAST  = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_sh_q, rx_sh_d;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d;
  logic [DATA_W-1:0] rx_hold_q, rx_hold_d;
  logic              valid_q, valid_d;
  logic              abort_q, abort_d;
  logic              lvl_d_q;
  logic              ss_d_q;

  logic lvl, lead, trail, ss_fall, ss_rise;
  logic [DATA_W-1:0] rx_next;

  // Edge detection relative to the idle level
  always_comb begin
    lvl     = sck_s_i ^ cpol_i;
    lead    = lvl & ~lvl_d_q;
    trail   = ~lvl & lvl_d_q;
    ss_fall = ss_d_q & ~ss_n_s_i;
    ss_rise = ~ss_d_q & ss_n_s_i;
    rx_next = {rx_sh_q[LAST-1:0], mosi_s_i};
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rx_sh_d   = rx_sh_q;
    tx_sh_d   = tx_sh_q;
    rx_hold_d = rx_hold_q;
    valid_d   = 1'b0;
    abort_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tx_sh_d = tx_word_i;
        if (ss_fall) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          rx_sh_d = '0;
        end
      end
      ST_SHIFT: begin
        if (ss_rise) begin
          abort_d = 1'b1;
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (lead) begin
          rx_sh_d = rx_next;
          if (cnt_q == CNT_LAST) begin
            rx_hold_d = rx_next;
            valid_d   = 1'b1;
            state_d   = ST_DONE;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else if (trail && (cnt_q != '0)) begin
          tx_sh_d = {tx_sh_q[LAST-1:0], 1'b0};
        end
      end
      ST_DONE: begin
        if (ss_rise) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rx_hold_q <= '0;
      valid_q   <= 1'b0;
      abort_q   <= 1'b0;
      lvl_d_q   <= 1'b0;
      ss_d_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      rx_sh_q   <= rx_sh_d;
      tx_sh_q   <= tx_sh_d;
      rx_hold_q <= rx_hold_d;
      valid_q   <= valid_d;
      abort_q   <= abort_d;
      lvl_d_q   <= lvl;
      ss_d_q    <= ss_n_s_i;
    end
  end

  assign start_o    = (state_q == ST_IDLE) & ss_fall;
  assign rx_data_o  = rx_hold_q;
  assign rx_valid_o = valid_q;
  assign abort_o    = abort_q;
  assign miso_o     = tx_sh_q[LAST];

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R7
  done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> $stable(rx_data_o));

  // R8
  abort_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (state_q == ST_IDLE && cnt_q == '0 && !rx_valid_o));

  // R5
  miso_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && !trail && !ss_rise) |=> $stable(miso_o));

endmodule

// File: rtl/spi_slave_cpha0.sv
module spi_slave_cpha0
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              abort_o,
  output logic              underrun_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe_o
);

  localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_SS;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_sync_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic [DATA_W-1:0]  tx_word;
  logic               start;
  logic               miso_bit;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_MOSI] = mosi_i;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_SS]   = ss_n_i;
  end

  spi_slv_sync #(
    .WIDTH   (PIN_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  spi_slv_txbuf #(
    .DATA_W (DATA_W)
  ) u_txbuf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tx_load_i),
    .data_i     (tx_data_i),
    .start_i    (start),
    .word_o     (tx_word),
    .ready_o    (tx_ready_o),
    .underrun_o (underrun_o)
  );

  spi_slv_shifter #(
    .DATA_W (DATA_W)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cpol_i     (cpol_i),
    .sck_s_i    (pins_s[PIN_SCK]),
    .mosi_s_i   (pins_s[PIN_MOSI]),
    .ss_n_s_i   (pins_s[PIN_SS]),
    .tx_word_i  (tx_word),
    .start_o    (start),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .abort_o    (abort_o),
    .miso_o     (miso_bit)
  );

  // Release the shared line asynchronously on deselect
  assign miso_oe_o = ~ss_n_i;
  assign miso_o    = miso_bit & ~ss_n_i;

  // R8
  abort_vs_underrun_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_o |-> !$past(start));

endmodule

// File: tb/spi_slave_cpha0_tb.sv
module spi_slave_cpha0_tb;

  localparam int HALF = 6;
  localparam int NVEC = 6;
  // {cpol, transmit byte, byte sent by master}
  localparam logic [16:0] VEC [NVEC] = '{
    17'h0A53C, 17'h100FF, 17'h0FF00, 17'h1817E, 17'h15AC3, 17'h00180
  };

  logic       clk;
  logic       rst_n;
  logic       cpol;
  logic       tx_load;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       abort_p;
  logic       underrun_p;
  logic       sck;
  logic       mosi;
  logic       ss_n;
  logic       miso;
  logic       miso_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int valid_cnt = 0;
  int abort_cnt = 0;
  int under_cnt = 0;
  int wide_cnt  = 0;
  logic       prev_valid = 1'b0;
  logic [7:0] last_rx = 8'h00;
  logic       done = 1'b0;

  spi_slave_cpha0 u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpol_i     (cpol),
    .tx_load_i  (tx_load),
    .tx_data_i  (tx_data),
    .tx_ready_o (tx_ready),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .abort_o    (abort_p),
    .underrun_o (underrun_p),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .ss_n_i     (ss_n),
    .miso_o     (miso),
    .miso_oe_o  (miso_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Event monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        valid_cnt <= valid_cnt + 1;
        last_rx   <= rx_data;
      end
      if (rx_valid && prev_valid) wide_cnt <= wide_cnt + 1;
      if (abort_p)    abort_cnt <= abort_cnt + 1;
      if (underrun_p) under_cnt <= under_cnt + 1;
      prev_valid <= rx_valid;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog R1..: actual hung expected finished");
      summary();
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] b);
    tx_data = b;
    tx_load = 1'b1;
    wait_cyc(1);
    tx_load = 1'b0;
  endtask

  // Select low, clock nbits cycles, leave select low
  task automatic xfer(input logic [7:0] mo, input int nbits,
                      input logic [7:0] exp_tx, output logic [7:0] mi);
    mi   = 8'h00;
    mosi = mo[7];
    ss_n = 1'b0;
    wait_cyc(1);
    check(32'(miso_oe), 32'd1, "R2 enable while selected");
    wait_cyc(HALF - 1);
    check(32'(miso), 32'(exp_tx[7]), "R3 MSB before first edge");
    check(32'(tx_ready), 32'd1, "R10 ready after start");
    for (int b = 0; b < nbits; b++) begin
      mi[7-b] = miso;
      sck = ~cpol;
      wait_cyc(HALF);
      sck = cpol;
      if (b < 7) mosi = mo[6-b];
      wait_cyc(HALF);
    end
  endtask

  task automatic deselect();
    ss_n = 1'b1;
    wait_cyc(4);
    check(32'(miso_oe), 32'd0, "R2 released when deselected");
    wait_cyc(2);
  endtask

  initial begin
    logic [7:0] mi;
    int vb, ab, ub;
    rst_n = 1'b0; cpol = 1'b0; tx_load = 1'b0; tx_data = 8'h00;
    sck = 1'b0; mosi = 1'b0; ss_n = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1 reset state
    check(32'(rx_valid),   32'd0, "R1 rx_valid");
    check(32'(rx_data),    32'h0, "R1 rx_data");
    check(32'(tx_ready),   32'd1, "R1 tx_ready");
    check(32'(abort_p),    32'd0, "R1 abort");
    check(32'(underrun_p), 32'd0, "R1 underrun");
    check(32'(miso_oe),    32'd0, "R2 released after reset");

    // Table of exchanges under both polarities (R4, R5, R6)
    for (int i = 0; i < NVEC; i++) begin
      cpol = VEC[i][16];
      sck  = VEC[i][16];
      wait_cyc(4);
      load_byte(VEC[i][15:8]);
      check(32'(tx_ready), 32'd0, "R10 ready drops after load");
      wait_cyc(4);
      vb = valid_cnt; ub = under_cnt;
      xfer(VEC[i][7:0], 8, VEC[i][15:8], mi);
      deselect();
      check(32'(valid_cnt - vb), 32'd1, "R6 one valid per byte");
      check(32'(last_rx), 32'(VEC[i][7:0]), "R4 received byte");
      check(32'(rx_data), 32'(VEC[i][7:0]), "R6 rx_data held");
      check(32'(mi), 32'(VEC[i][15:8]), "R5 transmitted byte");
      check(32'(under_cnt - ub), 32'd0, "R9 no underrun when loaded");
    end
    check(32'(wide_cnt), 32'd0, "R6 valid pulse width");

    // R8 early deselect
    cpol = 1'b0; sck = 1'b0;
    wait_cyc(4);
    load_byte(8'hC6);
    wait_cyc(4);
    vb = valid_cnt; ab = abort_cnt;
    xfer(8'hF0, 4, 8'hC6, mi);
    deselect();
    check(32'(abort_cnt - ab), 32'd1, "R8 abort pulse");
    check(32'(valid_cnt - vb), 32'd0, "R8 no valid on abort");

    // R9 resend without load, R8 realigned capture
    vb = valid_cnt; ub = under_cnt;
    xfer(8'h69, 8, 8'hC6, mi);
    deselect();
    check(32'(mi), 32'hC6, "R9 previous byte resent");
    check(32'(under_cnt - ub), 32'd1, "R9 underrun pulse");
    check(32'(last_rx), 32'h69, "R8 next byte aligned");
    check(32'(valid_cnt - vb), 32'd1, "R8 next byte valid");

    // R7 extra clocks under one select
    cpol = 1'b1; sck = 1'b1;
    wait_cyc(4);
    load_byte(8'h3E);
    wait_cyc(4);
    vb = valid_cnt;
    xfer(8'hA1, 8, 8'h3E, mi);
    mosi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sck = ~cpol; wait_cyc(HALF);
      sck = cpol;  wait_cyc(HALF);
    end
    check(32'(rx_data), 32'hA1, "R7 rx_data unchanged");
    deselect();
    check(32'(valid_cnt - vb), 32'd1, "R7 no second byte");
    check(32'(last_rx), 32'hA1, "R7 byte kept");
    check(32'(mi), 32'h3E, "R5 transmitted byte cpol1");

    done = 1'b1;
    summary();
  end

endmodule